// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block resolves a translation miss in hardware. When the translation buffer has no entry for an address, the walker reads the matching translation from a two-level table in memory and loads it into one buffer slot. No refill exception is raised. The walk takes three steps. First it reads a directory word. Then it reads the even and odd table entries that share one 8-byte slot. It reformats both entries into buffer low words and writes one buffer entry into the slot named by the random-index input. Last, it reports how the original access resolves against the new entry.

The directory base and the loaded table pointers are addresses in the unmapped kernel window. The walker removes the window offset (0x80000000) before it puts an address on its single-word read port. While a walk is in progress, the walker shows walk-specific values for three control registers: the faulting address, the context register and the entry-high register. Once the walk is over, those views go back to the values held outside. If the directory base is zero, the walker reads nothing and reports no-match, so the normal exception path runs instead.

Top module: `pt_walker`

## Requirements
- R1: A miss request is taken only when the walker is idle. `busy` rises on the edge that takes the request, stays high up to and including the cycle in which `res_valid` is high, and is low in the cycle after that.
- R2: If `dir_base` is zero when a request is taken, the walker makes no memory read and no buffer write. It reports code 3 (no-match) in the cycle after the request is taken.
- R3: The first read goes to (`dir_base` − 0x80000000) + 4 × vaddr[31:22].
- R4: The second read goes to (table pointer − 0x80000000) + 8 × vaddr[21:13], where the table pointer is the data returned by the first read. This read fetches the even entry. The third read fetches the odd entry at that address + 4.
- R5: Only one read is outstanding at a time. `mem_req` stays high with a stable `mem_addr` until `mem_rvalid` is seen, and `mem_req` is high only while `busy` is high.
- R6: After the odd entry arrives, `tlb_we` pulses for exactly one cycle with these values: `tlb_lo0` = even entry >> 6, `tlb_lo1` = odd entry >> 6, `tlb_hi` = {vaddr[31:13], 5'b0, ASID}, where ASID is `cur_entryhi[7:0]`, and `tlb_idx` = `rand_idx`.
- R7: `res_valid` is high for one cycle, the cycle after the buffer write. The half used is the odd one when vaddr[12] = 1 and the even one otherwise. If bit 1 (valid) of that low word is clear, the code is 1 (invalid). Otherwise, if the access is a write and bit 2 (dirty) is clear, the code is 2 (dirty). Otherwise the code is 0 (hit). The valid check takes precedence over the dirty check.
- R8: While `busy` is high:
  - `view_badvaddr` = faulting address.
  - `view_entryhi` = {vaddr[31:13], 13'b0} with ASID in bits 7:0.
  - `view_context` keeps bits 31:23 of `cur_context`, and bits 22:0 = (vaddr >> 9) & 0x7FFFF0.
- R9: While `busy` is low, each view output equals its `cur_*` input.
- R10: A request presented while a walk is running is ignored. It starts no read, does not change the address being walked, and causes no second result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| miss_valid | input | 1 | Miss request strobe |
| miss_vaddr | input | 32 | Faulting virtual address |
| miss_write | input | 1 | Access is a write |
| busy | output | 1 | Walk in progress |
| dir_base | input | 32 | Page directory base (kernel-window address), zero = not configured |
| mem_req | output | 1 | Word read request |
| mem_addr | output | 32 | Physical word address |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | 32 | Read data |
| rand_idx | input | IDX_W | Random replacement slot |
| tlb_we | output | 1 | Buffer entry write strobe |
| tlb_idx | output | IDX_W | Slot written |
| tlb_hi | output | 32 | Entry-high value written |
| tlb_lo0 | output | 32 | Even low word written |
| tlb_lo1 | output | 32 | Odd low word written |
| cur_context | input | 32 | Context register value outside a walk |
| cur_entryhi | input | 32 | Entry-high register value outside a walk (ASID in 7:0) |
| cur_badvaddr | input | 32 | Bad-address register value outside a walk |
| view_context | output | 32 | Context register as seen now |
| view_entryhi | output | 32 | Entry-high register as seen now |
| view_badvaddr | output | 32 | Bad-address register as seen now |
| res_valid | output | 1 | Result strobe |
| res_code | output | 2 | 0 hit, 1 invalid, 2 dirty, 3 no-match |

## Verification
The assertions check these behaviours on every cycle:
- the read handshake: a request held with a stable address, and a request only while busy;
- that a request taken in idle raises busy;
- that busy falls right after the result;
- that a buffer write is always followed by a resolved, non-no-match result;
- that a no-match result never comes after a write.

Only the bench scenarios can show the rest:
- the address arithmetic of all three reads;
- the shifted low words;
- the choice of half and the valid-before-dirty precedence;
- the view values during and after a walk;
- that a request arriving mid-walk leaves no trace.

// File: rtl/ptw_pkg.sv
package ptw_pkg;

    localparam logic [31:0] KSEG_BASE  = 32'h8000_0000;
    localparam int unsigned PTE_SHIFT  = 6;
    localparam int unsigned CTX_SHIFT  = 9;
    localparam logic [31:0] CTX_FIELD  = 32'h007F_FFFF;
    localparam logic [31:0] CTX_MASK   = 32'h007F_FFF0;
    localparam int unsigned ASID_W     = 8;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_DIR,
        ST_EVEN,
        ST_ODD,
        ST_WRITE,
        ST_RESP
    } walk_state_e;

    typedef enum logic [1:0] {
        RES_HIT     = 2'd0,
        RES_INVALID = 2'd1,
        RES_DIRTY   = 2'd2,
        RES_NOMATCH = 2'd3
    } walk_res_e;

    typedef struct packed {
        logic [31:0] va;
        logic        wr;
        logic        nomatch;
        logic [31:0] base;
    } walk_req_t;

    function automatic logic [31:0] to_phys(input logic [31:0] a);
        return a - KSEG_BASE;
    endfunction

    function automatic logic [31:0] dir_word_addr(input logic [31:0] base,
                                                  input logic [31:0] va);
        return to_phys(base) + {20'd0, va[31:22], 2'b00};
    endfunction

    function automatic logic [31:0] pte_pair_addr(input logic [31:0] tptr,
                                                  input logic [31:0] va);
        return to_phys(tptr) + {20'd0, va[21:13], 3'b000};
    endfunction

    function automatic logic [31:0] walk_hi(input logic [31:0] va,
                                            input logic [ASID_W-1:0] asid);
        return {va[31:13], 5'd0, asid};
    endfunction

    function automatic logic [31:0] walk_ctx(input logic [31:0] cur,
                                             input logic [31:0] va);
        return (cur & ~CTX_FIELD) | ((va >> CTX_SHIFT) & CTX_MASK);
    endfunction

endpackage

// File: rtl/ptw_addr_gen.sv
module ptw_addr_gen
    import ptw_pkg::*;
(
    input  walk_state_e state,
    input  logic [31:0] base,
    input  logic [31:0] va,
    input  logic [31:0] tptr,
    output logic        mem_req,
    output logic [31:0] mem_addr
);
    logic [31:0] pair_addr;

    assign pair_addr = pte_pair_addr(tptr, va);

    always_comb begin
        mem_req  = 1'b0;
        mem_addr = '0;
        case (state)
            ST_DIR: begin
                mem_req  = 1'b1;
                mem_addr = dir_word_addr(base, va);
            end
            ST_EVEN: begin
                mem_req  = 1'b1;
                mem_addr = pair_addr;
            end
            ST_ODD: begin
                mem_req  = 1'b1;
                mem_addr = pair_addr + 32'd4;
            end
            default: begin
                mem_req  = 1'b0;
                mem_addr = '0;
            end
        endcase
    end
endmodule

// File: rtl/ptw_resolve.sv
module ptw_resolve
    import ptw_pkg::*;
(
    input  logic [31:0] lo0,
    input  logic [31:0] lo1,
    input  logic        odd_half,
    input  logic        write,
    input  logic        nomatch,
    output walk_res_e   code
);
    logic [31:0] sel;

    assign sel = odd_half ? lo1 : lo0;

    always_comb begin
        if (nomatch)
            code = RES_NOMATCH;
        else if (!sel[1])
            code = RES_INVALID;
        else if (write && !sel[2])
            code = RES_DIRTY;
        else
            code = RES_HIT;
    end
endmodule

// File: rtl/ptw_cp0_view.sv
module ptw_cp0_view
    import ptw_pkg::*;
(
    input  logic        walking,
    input  logic [31:0] va,
    input  logic [31:0] cur_context,
    input  logic [31:0] cur_entryhi,
    input  logic [31:0] cur_badvaddr,
    output logic [31:0] view_context,
    output logic [31:0] view_entryhi,
    output logic [31:0] view_badvaddr
);
    logic [31:0] hi_walk;

    assign hi_walk       = {va[31:13], 13'd0} | {24'd0, cur_entryhi[ASID_W-1:0]};
    assign view_context  = walking ? walk_ctx(cur_context, va) : cur_context;
    assign view_entryhi  = walking ? hi_walk : cur_entryhi;
    assign view_badvaddr = walking ? va : cur_badvaddr;
endmodule

// File: rtl/pt_walker.sv
module pt_walker
    import ptw_pkg::*;
#(
    parameter  int unsigned TLB_ENTRIES = 32,
    localparam int unsigned IDX_W = (TLB_ENTRIES > 1) ? $clog2(TLB_ENTRIES) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             miss_valid,
    input  logic [31:0]      miss_vaddr,
    input  logic             miss_write,
    output logic             busy,
    input  logic [31:0]      dir_base,
    output logic             mem_req,
    output logic [31:0]      mem_addr,
    input  logic             mem_rvalid,
    input  logic [31:0]      mem_rdata,
    input  logic [IDX_W-1:0] rand_idx,
    output logic             tlb_we,
    output logic [IDX_W-1:0] tlb_idx,
    output logic [31:0]      tlb_hi,
    output logic [31:0]      tlb_lo0,
    output logic [31:0]      tlb_lo1,
    input  logic [31:0]      cur_context,
    input  logic [31:0]      cur_entryhi,
    input  logic [31:0]      cur_badvaddr,
    output logic [31:0]      view_context,
    output logic [31:0]      view_entryhi,
    output logic [31:0]      view_badvaddr,
    output logic             res_valid,
    output logic [1:0]       res_code
);
    walk_state_e state;
    walk_req_t   req_q;
    logic [31:0] tptr_q;
    logic [31:0] lo0_q;
    logic [31:0] lo1_q;
    walk_res_e   code;

    // Walk sequencer: one read in flight, strictly ordered directory -> even -> odd.
    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= ST_IDLE;
            req_q  <= '0;
            tptr_q <= '0;
            lo0_q  <= '0;
            lo1_q  <= '0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (miss_valid) begin
                        req_q.va      <= miss_vaddr;
                        req_q.wr      <= miss_write;
                        req_q.base    <= dir_base;
                        req_q.nomatch <= (dir_base == '0);
                        state         <= (dir_base == '0) ? ST_RESP : ST_DIR;
                    end
                end
                ST_DIR: begin
                    if (mem_rvalid) begin
                        tptr_q <= mem_rdata;
                        state  <= ST_EVEN;
                    end
                end
                ST_EVEN: begin
                    if (mem_rvalid) begin
                        lo0_q <= mem_rdata >> PTE_SHIFT;
                        state <= ST_ODD;
                    end
                end
                ST_ODD: begin
                    if (mem_rvalid) begin
                        lo1_q <= mem_rdata >> PTE_SHIFT;
                        state <= ST_WRITE;
                    end
                end
                ST_WRITE: state <= ST_RESP;
                ST_RESP:  state <= ST_IDLE;
                default:  state <= ST_IDLE;
            endcase
        end
    end

    assign busy = (state != ST_IDLE);

    ptw_addr_gen u_addr_gen (
        .state    (state),
        .base     (req_q.base),
        .va       (req_q.va),
        .tptr     (tptr_q),
        .mem_req  (mem_req),
        .mem_addr (mem_addr)
    );

    ptw_resolve u_resolve (
        .lo0      (lo0_q),
        .lo1      (lo1_q),
        .odd_half (req_q.va[12]),
        .write    (req_q.wr),
        .nomatch  (req_q.nomatch),
        .code     (code)
    );

    ptw_cp0_view u_view (
        .walking       (busy),
        .va            (req_q.va),
        .cur_context   (cur_context),
        .cur_entryhi   (cur_entryhi),
        .cur_badvaddr  (cur_badvaddr),
        .view_context  (view_context),
        .view_entryhi  (view_entryhi),
        .view_badvaddr (view_badvaddr)
    );

    assign tlb_we    = (state == ST_WRITE);
    assign tlb_idx   = rand_idx;
    assign tlb_hi    = walk_hi(req_q.va, cur_entryhi[ASID_W-1:0]);
    assign tlb_lo0   = lo0_q;
    assign tlb_lo1   = lo1_q;
    assign res_valid = (state == ST_RESP);
    assign res_code  = code;

    // R1: a request taken in idle makes the walker busy on the next cycle
    a_r1_accept: assert property (@(posedge clk) disable iff (rst)
        (!busy && miss_valid) |=> busy)
        else $error("a_r1_accept");

    // R1: busy drops right after the result cycle
    a_r1_release: assert property (@(posedge clk) disable iff (rst)
        res_valid |=> !busy)
        else $error("a_r1_release");

    // R5: request and address held until data returns
    a_r5_hold: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_rvalid) |=> (mem_req && $stable(mem_addr)))
        else $error("a_r5_hold");

    // R5: memory is only touched during a walk
    a_r5_in_walk: assert property (@(posedge clk) disable iff (rst)
        mem_req |-> busy)
        else $error("a_r5_in_walk");

    // R7: a buffer write is followed by a resolved result
    a_r7_after_write: assert property (@(posedge clk) disable iff (rst)
        tlb_we |=> (res_valid && res_code != RES_NOMATCH))
        else $error("a_r7_after_write");

    // R2: a no-match result never follows a buffer write
    a_r2_no_write: assert property (@(posedge clk) disable iff (rst)
        (res_valid && res_code == RES_NOMATCH) |-> !$past(tlb_we))
        else $error("a_r2_no_write");

endmodule

// File: tb/pt_walker_bench.sv
module pt_walker_bench;
    localparam int          TLB_N = 32;
    localparam int          IW    = 5;
    localparam logic [31:0] KSEG  = 32'h8000_0000;
    localparam logic [31:0] DIRB  = 32'h8010_0000;
    localparam logic [31:0] TPTR  = 32'h8020_0000;
    localparam logic [31:0] CCTX  = 32'hABCD_1234;
    localparam logic [31:0] CEHI  = 32'h5555_50A5;
    localparam logic [31:0] CBVA  = 32'h0BAD_0000;

    typedef struct packed {
        logic [31:0] va;
        logic        wr;
        logic [31:0] pe;
        logic [31:0] po;
        logic [1:0]  code;
        logic [1:0]  lat;
    } vec_t;

    localparam int NV = 7;
    localparam vec_t VECS [NV] = '{
        '{32'h0040_2000, 1'b0, 32'h1234_5780, 32'h0000_0000, 2'd0, 2'd1},
        '{32'h7FFF_F000, 1'b1, 32'h0000_0000, 32'h0000_0180, 2'd0, 2'd2},
        '{32'h1234_5000, 1'b0, 32'hFFFF_FFC0, 32'h0000_0100, 2'd1, 2'd3},
        '{32'hC000_0000, 1'b1, 32'h0000_0080, 32'h0000_0000, 2'd2, 2'd1},
        '{32'hC000_0000, 1'b0, 32'h0000_0080, 32'h0000_0000, 2'd0, 2'd2},
        '{32'h0000_1000, 1'b1, 32'h0000_0180, 32'h0000_0080, 2'd2, 2'd1},
        '{32'h0000_0000, 1'b1, 32'h0000_0100, 32'h0000_0000, 2'd1, 2'd3}
    };

    logic          clk, rst;
    logic          miss_valid, miss_write, busy;
    logic [31:0]   miss_vaddr, dir_base;
    logic          mem_req, mem_rvalid;
    logic [31:0]   mem_addr, mem_rdata;
    logic [IW-1:0] rand_idx, tlb_idx;
    logic          tlb_we, res_valid;
    logic [31:0]   tlb_hi, tlb_lo0, tlb_lo1;
    logic [31:0]   cur_context, cur_entryhi, cur_badvaddr;
    logic [31:0]   view_context, view_entryhi, view_badvaddr;
    logic [1:0]    res_code;

    pt_walker #(.TLB_ENTRIES(TLB_N)) u_pt_walker (
        .clk(clk), .rst(rst),
        .miss_valid(miss_valid), .miss_vaddr(miss_vaddr), .miss_write(miss_write),
        .busy(busy), .dir_base(dir_base),
        .mem_req(mem_req), .mem_addr(mem_addr), .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
        .rand_idx(rand_idx), .tlb_we(tlb_we), .tlb_idx(tlb_idx),
        .tlb_hi(tlb_hi), .tlb_lo0(tlb_lo0), .tlb_lo1(tlb_lo1),
        .cur_context(cur_context), .cur_entryhi(cur_entryhi), .cur_badvaddr(cur_badvaddr),
        .view_context(view_context), .view_entryhi(view_entryhi), .view_badvaddr(view_badvaddr),
        .res_valid(res_valid), .res_code(res_code)
    );

    initial clk = 1'b0;
    always #10 clk = ~clk;

    int n_run  = 0;
    int n_fail = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // memory responder and buffer-write monitor
    int          lat = 1;
    int          cnt = 0;
    int          n_reads = 0;
    int          n_unstable = 0;
    int          n_we = 0;
    logic [31:0] log_a [4];
    logic [31:0] first_a = '0;
    logic [31:0] pe_v = '0, po_v = '0, exp_dir = '0, exp_even = '0;
    logic [31:0] cap_hi = '0, cap_lo0 = '0, cap_lo1 = '0;
    logic [IW-1:0] cap_idx = '0;

    initial begin
        mem_rvalid = 1'b0;
        mem_rdata  = '0;
        forever begin
            @(negedge clk);
            if (mem_rvalid) begin
                mem_rvalid = 1'b0;
                cnt = 0;
            end else if (mem_req) begin
                if (cnt == 0) first_a = mem_addr;
                else if (mem_addr != first_a) n_unstable++;
                cnt++;
                if (cnt >= lat) begin
                    mem_rvalid = 1'b1;
                    if (n_reads < 4) log_a[n_reads] = mem_addr;
                    n_reads++;
                    mem_rdata = (mem_addr == exp_dir)        ? TPTR :
                                (mem_addr == exp_even)       ? pe_v :
                                (mem_addr == exp_even + 32'd4) ? po_v : 32'h0;
                end
            end
        end
    end

    initial begin
        forever begin
            @(negedge clk);
            if (tlb_we) begin
                n_we++;
                cap_hi  = tlb_hi;
                cap_lo0 = tlb_lo0;
                cap_lo1 = tlb_lo1;
                cap_idx = tlb_idx;
            end
        end
    end

    task automatic run_walk(input logic [31:0] va, input logic wr,
                            input logic [31:0] pe, input logic [31:0] po,
                            input int lat_i, input logic [1:0] exp_code);
        bit          got;
        logic [1:0]  code_c;
        logic [31:0] ectx, ehi;
        int          reads_after;
        exp_dir  = (dir_base - KSEG) + {20'd0, va[31:22], 2'b00};
        exp_even = (TPTR - KSEG) + {20'd0, va[21:13], 3'b000};
        ectx     = (CCTX & ~32'h007F_FFFF) | ((va >> 9) & 32'h007F_FFF0);
        ehi      = {va[31:13], 13'd0} | {24'd0, CEHI[7:0]};
        pe_v = pe; po_v = po; lat = lat_i;
        n_reads = 0; n_we = 0; n_unstable = 0;

        @(negedge clk);
        miss_valid = 1'b1; miss_vaddr = va; miss_write = wr;
        @(negedge clk);
        // R10: a spurious request while busy, with different address and direction
        miss_vaddr = ~va; miss_write = ~wr;
        chk(busy == 1'b1, "R1", "busy after accept", {31'd0, busy}, 32'd1);
        chk(view_badvaddr == va, "R8", "badvaddr view", view_badvaddr, va);
        chk(view_context == ectx, "R8", "context view", view_context, ectx);
        chk(view_entryhi == ehi, "R8", "entryhi view", view_entryhi, ehi);
        got = res_valid;
        code_c = res_code;
        @(negedge clk);
        miss_valid = 1'b0; miss_vaddr = va; miss_write = wr;
        if (!got) begin
            for (int i = 0; i < 60 && !res_valid; i++) @(negedge clk);
            chk(res_valid == 1'b1, "R7", "result strobe", {31'd0, res_valid}, 32'd1);
            code_c = res_code;
            @(negedge clk);
        end
        chk(code_c == exp_code, "R7", "result code", {30'd0, code_c}, {30'd0, exp_code});
        chk(busy == 1'b0, "R1", "busy after result", {31'd0, busy}, 32'd0);
        chk(res_valid == 1'b0, "R7", "single result", {31'd0, res_valid}, 32'd0);
        chk(view_context == CCTX && view_entryhi == CEHI && view_badvaddr == CBVA,
            "R9", "views restored", view_context, CCTX);
        if (dir_base == '0) begin
            chk(n_reads == 0, "R2", "no reads", n_reads, 32'd0);
            chk(n_we == 0, "R2", "no buffer write", n_we, 32'd0);
        end else begin
            chk(n_reads == 3, "R4", "read count", n_reads, 32'd3);
            chk(log_a[0] == exp_dir, "R3", "directory address", log_a[0], exp_dir);
            chk(log_a[1] == exp_even, "R4", "even address", log_a[1], exp_even);
            chk(log_a[2] == exp_even + 32'd4, "R4", "odd address", log_a[2], exp_even + 32'd4);
            chk(n_unstable == 0, "R5", "address held", n_unstable, 32'd0);
            chk(n_we == 1, "R6", "one buffer write", n_we, 32'd1);
            chk(cap_lo0 == (pe >> 6), "R6", "lo0", cap_lo0, pe >> 6);
            chk(cap_lo1 == (po >> 6), "R6", "lo1", cap_lo1, po >> 6);
            chk(cap_hi == {va[31:13], 5'd0, CEHI[7:0]}, "R6", "hi", cap_hi,
                {va[31:13], 5'd0, CEHI[7:0]});
            chk(cap_idx == rand_idx, "R6", "slot", {27'd0, cap_idx}, {27'd0, rand_idx});
        end
        reads_after = n_reads;
        repeat (4) @(negedge clk);
        chk(n_reads == reads_after && busy == 1'b0, "R10", "spurious request ignored",
            n_reads, reads_after);
    endtask

    // watchdog
    initial begin
        repeat (150000) @(posedge clk);
        n_run++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        rst = 1'b1;
        miss_valid = 1'b0; miss_vaddr = '0; miss_write = 1'b0;
        dir_base = DIRB; rand_idx = '0;
        cur_context = CCTX; cur_entryhi = CEHI; cur_badvaddr = CBVA;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(busy == 1'b0 && res_valid == 1'b0, "R1", "reset idle", {31'd0, busy}, 32'd0);
        chk(mem_req == 1'b0 && tlb_we == 1'b0, "R5", "reset quiet", {31'd0, mem_req}, 32'd0);
        chk(view_context == CCTX && view_entryhi == CEHI && view_badvaddr == CBVA,
            "R9", "reset views", view_badvaddr, CBVA);

        for (int v = 0; v < NV; v++) begin
            rand_idx = IW'(v * 5 + 3);
            run_walk(VECS[v].va, VECS[v].wr, VECS[v].pe, VECS[v].po,
                     int'(VECS[v].lat), VECS[v].code);
        end

        // R2: unconfigured directory
        dir_base = '0;
        run_walk(32'h0040_2000, 1'b0, 32'h1234_5780, 32'h0, 1, 2'd3);
        dir_base = DIRB;
        // walker still works after a no-match
        run_walk(32'hFFFF_E000, 1'b1, 32'h0000_01C0, 32'h0, 2, 2'd0);

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule